// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter Channel

This block is a single transmit lane of an asynchronous serial controller. A host places a character of five to eight bits on a parallel bus and pulses a write strobe. The block turns the character into a frame on a single line. The frame is a low start bit, then the data bits with the least significant first, then an optional parity bit, then a stop period at the high (mark) level. The stop period lasts one, one and a half or two bit times.

Bit timing comes from a clock-enable tick that runs at a fixed multiple of the bit rate. An 8-bit control byte sets the parity, the stop length and the tick multiple. A separate 2-bit input sets the character length. Everything that shapes a frame is captured when the write is accepted, so the host may change the inputs while a frame is in flight. A stop-length code of zero stands for a synchronous framing mode. The transmitter does not support that mode, so it keeps the line idle and refuses characters while the code is zero.

Top module: `async_tx_channel`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0 and `wr_overrun` is 0.
- R2: A frame is a 0 start bit followed by the data bits LSB first; `char_len` codes 00, 01, 10 and 11 send 5, 6, 7 and 8 data bits.
- R3: Control bit 0 set adds one parity bit right after the last data bit; with bit 0 clear the stop period follows the data directly.
- R4: Control bit 1 picks the parity sense: 1 makes the count of ones over data plus parity even, 0 makes it odd.
- R5: Control bits 7:6 set the ticks per bit: 00 is 1, 01 is 16, 10 is 32 and 11 is 64. Only cycles with `tick` high advance the frame.
- R6: Control bits 3:2 equal to 01 give a stop period of one bit time, and 11 gives two bit times, with the line at 1.
- R7: Control bits 3:2 equal to 10 give a stop period of one and a half bit times (24 ticks at 16 ticks per bit); at 1 tick per bit it lasts 2 ticks.
- R8: While control bits 3:2 are 00, a write is not accepted: `txd` stays 1, `busy` stays 0 and `wr_overrun` is not set.
- R9: `busy` rises on the clock edge that accepts a write and falls on the edge that consumes the last tick of the stop period; at that same edge `txd` returns to 1.
- R10: A write while `busy` is high does not change the frame in flight and sets `wr_overrun`, which stays set until reset.
- R11: Data, character length and control fields are sampled when the write is accepted; later changes to them do not affect the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Clock enable at a multiple of the bit rate |
| ctrl | input | 8 | Control byte: parity enable [0], parity even [1], stop select [3:2], tick multiple [7:6] |
| char_len | input | 2 | Character length code (5 to 8 bits) |
| wr_en | input | 1 | Host write strobe, one cycle |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |
| wr_overrun | output | 1 | Sticky: a write arrived while busy |

## Verification
A wrong data count, shift position or latched parity shows at the port as a wrong line level during the very bit time it affects. The bench compares `txd` in every cycle against a frame model indexed by ticks consumed, so the first wrong bit is caught. A wrong tick limit for a bit or for the stop period moves every later transition. It shows as a `busy` fall that comes early or late by at least one tick, and the frame-length check catches it. A state machine stuck outside idle keeps `busy` high past the computed frame end, so the fault appears on the first cycle after the expected end.

// File: rtl/tx_pkg.sv
package tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    localparam logic [1:0] STOP_SYNC = 2'b00;
    localparam logic [1:0] STOP_ONE  = 2'b01;
    localparam logic [1:0] STOP_HALF = 2'b10;
    localparam logic [1:0] STOP_TWO  = 2'b11;

    localparam int CTRL_PAR_EN  = 0;
    localparam int CTRL_PAR_EVN = 1;
    localparam int CTRL_STOP_LO = 2;
    localparam int CTRL_RATE_LO = 6;

endpackage

// File: rtl/tx_tick_timer.sv
module tx_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         last
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;
    logic at_end;

    always_comb begin
        t_d    = t_q;
        at_end = (t_q.cnt == (limit - W'(1)));
        last   = tick && !restart && at_end;
        if (restart) begin
            t_d.cnt = '0;
        end else if (tick) begin
            if (at_end) t_d.cnt = '0;
            else        t_d.cnt = t_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

endmodule

// File: rtl/tx_parity_gen.sv
module tx_parity_gen #(
    parameter int MAX_BITS = 8,
    parameter int LEN_W    = 2
) (
    input  logic [MAX_BITS-1:0] data,
    input  logic [LEN_W-1:0]    len_code,
    input  logic                even,
    output logic                par_bit
);

    localparam int MIN_BITS = MAX_BITS - (2 ** LEN_W) + 1;
    localparam int NB_W     = $clog2(MAX_BITS + 1);

    logic [NB_W-1:0]     nbits;
    logic [MAX_BITS-1:0] mask;

    assign nbits = NB_W'(MIN_BITS) + NB_W'(len_code);

    for (genvar g = 0; g < MAX_BITS; g++) begin : g_mask
        assign mask[g] = (NB_W'(g) < nbits);
    end

    // even sense: parity bit equals XOR of data; odd sense inverts it
    assign par_bit = (^(data & mask)) ^ ~even;

endmodule

// File: rtl/async_tx_channel.sv
module async_tx_channel #(
    parameter int MAX_BITS = 8,
    parameter int LEN_W    = 2,
    parameter int RATE_A   = 1,
    parameter int RATE_B   = 16,
    parameter int RATE_C   = 32,
    parameter int RATE_D   = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic [7:0]          ctrl,
    input  logic [LEN_W-1:0]    char_len,
    input  logic                wr_en,
    input  logic [MAX_BITS-1:0] wr_data,
    output logic                txd,
    output logic                busy,
    output logic                wr_overrun
);
    import tx_pkg::*;

    localparam int MIN_BITS = MAX_BITS - (2 ** LEN_W) + 1;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);
    localparam int TICK_W   = $clog2(2 * RATE_D + 1);

    typedef struct packed {
        tx_state_e           st;
        logic [MAX_BITS-1:0] sh;
        logic [CNT_W-1:0]    left;
        logic                par_en;
        logic                par_bit;
        logic [1:0]          stop;
        logic [1:0]          rate;
        logic                txd;
        logic                ovr;
    } regs_t;

    regs_t r_d, r_q;

    logic              accept;
    logic              last;
    logic              restart;
    logic              new_par;
    logic [TICK_W-1:0] bit_len;
    logic [TICK_W-1:0] stop_len;
    logic [TICK_W-1:0] limit;

    function automatic logic [TICK_W-1:0] ticks_per_bit(input logic [1:0] code);
        case (code)
            2'b00:   return TICK_W'(RATE_A);
            2'b01:   return TICK_W'(RATE_B);
            2'b10:   return TICK_W'(RATE_C);
            default: return TICK_W'(RATE_D);
        endcase
    endfunction

    tx_parity_gen #(
        .MAX_BITS (MAX_BITS),
        .LEN_W    (LEN_W)
    ) u_par (
        .data     (wr_data),
        .len_code (char_len),
        .even     (ctrl[CTRL_PAR_EVN]),
        .par_bit  (new_par)
    );

    tx_tick_timer #(
        .W (TICK_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .restart (restart),
        .limit   (limit),
        .last    (last)
    );

    // bit and stop period lengths for the frame in flight
    always_comb begin
        bit_len = ticks_per_bit(r_q.rate);
        case (r_q.stop)
            STOP_HALF: stop_len = (bit_len == TICK_W'(1)) ? TICK_W'(2)
                                                          : bit_len + (bit_len >> 1);
            STOP_TWO:  stop_len = bit_len << 1;
            default:   stop_len = bit_len;
        endcase
        limit   = (r_q.st == ST_STOP) ? stop_len : bit_len;
        restart = (r_q.st == ST_IDLE);
    end

    always_comb begin
        r_d    = r_q;
        accept = wr_en && (r_q.st == ST_IDLE)
                 && (ctrl[CTRL_STOP_LO +: 2] != STOP_SYNC);

        if (wr_en && (r_q.st != ST_IDLE)) r_d.ovr = 1'b1;

        case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.st      = ST_START;
                    r_d.sh      = wr_data;
                    r_d.left    = CNT_W'(MIN_BITS) + CNT_W'(char_len);
                    r_d.par_en  = ctrl[CTRL_PAR_EN];
                    r_d.par_bit = new_par;
                    r_d.stop    = ctrl[CTRL_STOP_LO +: 2];
                    r_d.rate    = ctrl[CTRL_RATE_LO +: 2];
                end
            end
            ST_START: begin
                if (last) r_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (last) begin
                    r_d.sh   = r_q.sh >> 1;
                    r_d.left = r_q.left - CNT_W'(1);
                    if (r_q.left == CNT_W'(1))
                        r_d.st = r_q.par_en ? ST_PAR : ST_STOP;
                end
            end
            ST_PAR: begin
                if (last) r_d.st = ST_STOP;
            end
            ST_STOP: begin
                if (last) r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase

        case (r_d.st)
            ST_START: r_d.txd = 1'b0;
            ST_DATA:  r_d.txd = r_d.sh[0];
            ST_PAR:   r_d.txd = r_d.par_bit;
            default:  r_d.txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q     <= '0;
            r_q.st  <= ST_IDLE;
            r_q.txd <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign txd        = r_q.txd;
    assign busy       = (r_q.st != ST_IDLE);
    assign wr_overrun = r_q.ovr;

endmodule

// File: rtl/tx_chk.sv
module tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] ctrl,
    input logic       txd,
    input logic       busy,
    input logic       wr_overrun
);

    AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R9

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd); // R2

    AST_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && ctrl[3:2] != 2'b00) |=> busy); // R9

    AST_SYNC_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && wr_en && ctrl[3:2] == 2'b00) |=> (!busy && txd)); // R8

    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_en) |=> wr_overrun); // R10

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_overrun |=> wr_overrun); // R10

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_overrun) |-> $past(busy && wr_en)); // R10

    AST_END_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(txd)); // R6

endmodule

bind async_tx_channel tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .ctrl       (ctrl),
    .txd        (txd),
    .busy       (busy),
    .wr_overrun (wr_overrun)
);

// File: tb/sim_async_tx_channel.sv
module sim_async_tx_channel;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] ctrl = 8'h04;
    logic [1:0] char_len = 2'b00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txd;
    logic       busy;
    logic       wr_overrun;

    int checks = 0;
    int failures = 0;
    int wd = 0;

    always #5 clk = ~clk;

    async_tx_channel u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ctrl       (ctrl),
        .char_len   (char_len),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .txd        (txd),
        .busy       (busy),
        .wr_overrun (wr_overrun)
    );

    always @(posedge clk) begin
        wd++;
        if (wd > 190000) begin
            failures++;
            $display("FAIL R9 watchdog expired act=%0d exp=%0d", wd, 190000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    function automatic int ndiv(input logic [1:0] r);
        case (r)
            2'b00:   return 1;
            2'b01:   return 16;
            2'b10:   return 32;
            default: return 64;
        endcase
    endfunction

    function automatic int stop_ticks(input logic [1:0] s, input int n);
        if (s == 2'b10) return (n == 1) ? 2 : n + n / 2;
        if (s == 2'b11) return 2 * n;
        return n;
    endfunction

    function automatic logic exp_bit(input int k, input int n, input int nb,
                                     input logic pen, input logic pb,
                                     input logic [7:0] d);
        int seg;
        seg = k / n;
        if (seg == 0) return 1'b0;
        if (seg <= nb) return d[seg-1];
        if (pen && seg == nb + 1) return pb;
        return 1'b1;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        wr_en = 1'b0;
        tick  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Sends one frame and compares the line each cycle against the model,
    // indexed by ticks consumed since the accepting edge.
    task automatic run_frame(input logic [7:0] c, input logic [1:0] len,
                             input logic [7:0] d, input int p, input bit inject,
                             input string tag);
        int n, nb, f, k, cyc, bad_t, bad_b, act_t, exp_t, bad_k;
        logic pen, pb, injected;
        logic [7:0] masked;
        n   = ndiv(c[7:6]);
        nb  = 5 + int'(len);
        pen = c[0];
        masked = d & ((8'h01 << nb) - 8'h01);
        pb  = c[1] ? ^masked : ~^masked;
        f   = n * (1 + nb + int'(pen)) + stop_ticks(c[3:2], n);
        bad_t = 0; bad_b = 0; act_t = 0; exp_t = 0; bad_k = 0;
        injected = 1'b0;
        ctrl = c; char_len = len; wr_data = d; wr_en = 1'b1; tick = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        k = 0; cyc = 0;
        forever begin
            logic eb;
            eb = (k < f) ? exp_bit(k, n, nb, pen, pb, d) : 1'b1;
            if (busy !== (k < f) && bad_b == 0) begin
                bad_b = 1; bad_k = k;
            end
            if (txd !== eb && bad_t == 0) begin
                bad_t = 1; act_t = txd; exp_t = eb;
            end
            if (k >= f) break;
            tick = ((cyc % p) == 0);
            if (inject && !injected && k == 2 * n) begin
                wr_en = 1'b1; wr_data = ~d; ctrl = c ^ 8'h03; char_len = ~len;
                injected = 1'b1;
            end else begin
                wr_en = 1'b0;
            end
            if (tick) k++;
            cyc++;
            @(negedge clk);
        end
        tick = 1'b0; wr_en = 1'b0; ctrl = c; char_len = len;
        chk(bad_t == 0, {tag, " line level"}, act_t, exp_t);
        chk(bad_b == 0, "R9 busy span (ticks at first mismatch)", bad_k, f);
    endtask

    initial begin
        do_reset();
        // R1: reset state
        chk(txd === 1'b1, "R1 txd after reset", txd, 1);
        chk(busy === 1'b0, "R1 busy after reset", busy, 0);
        chk(wr_overrun === 1'b0, "R1 overrun after reset", wr_overrun, 0);

        // Sweep: R2 lengths, R3 R4 parity modes, R6 R7 stop codes, R5 rates x1/x16
        for (int r = 0; r < 2; r++)
            for (int l = 0; l < 4; l++)
                for (int pm = 0; pm < 3; pm++)
                    for (int s = 1; s < 4; s++)
                        for (int v = 0; v < 2; v++) begin
                            logic [7:0] c, d;
                            logic [1:0] pbits;
                            int per;
                            pbits = (pm == 0) ? 2'b00 : (pm == 1) ? 2'b01 : 2'b11;
                            c = {2'(r), 2'b00, 2'(s), pbits};
                            d = 8'hA5 ^ 8'((l * 37 + pm * 11 + s * 5 + v * 91) & 255);
                            per = (r == 0 && v == 1) ? 3 : 1;
                            run_frame(c, 2'(l), d, per, 1'b0, "R2 R3 R4 R6 R7 R5");
                        end
        chk(wr_overrun === 1'b0, "R10 no overrun without busy write", wr_overrun, 0);

        // R5: slower tick multiples
        run_frame(8'b10_00_01_11, 2'b11, 8'h96, 1, 1'b0, "R5 x32");
        run_frame(8'b11_00_10_01, 2'b10, 8'h4B, 2, 1'b0, "R5 R7 x64");

        // R8: synchronous code refuses writes
        ctrl = 8'b01_00_00_01; wr_data = 8'h00; wr_en = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < 40; i++) begin
                if (txd !== 1'b1 || busy !== 1'b0) bad++;
                @(negedge clk);
            end
            chk(bad == 0, "R8 sync code write refused (bad cycles)", bad, 0);
        end
        chk(wr_overrun === 1'b0, "R8 sync code leaves overrun clear", wr_overrun, 0);
        tick = 1'b0;

        // R10 R11: write mid-frame ignored, config changes ignored
        run_frame(8'b01_00_01_01, 2'b01, 8'h2D, 1, 1'b1, "R11 R10 frame unchanged");
        chk(wr_overrun === 1'b1, "R10 overrun set by busy write", wr_overrun, 1);
        repeat (5) @(negedge clk);
        chk(wr_overrun === 1'b1, "R10 overrun sticky", wr_overrun, 1);
        do_reset();
        chk(wr_overrun === 1'b0, "R1 R10 overrun cleared by reset", wr_overrun, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule